// File: doc/BRIEF.md
# Composite Sync Separator

This block takes a composite sync signal that has already been sliced to one bit and splits it into a horizontal sync pulse and a vertical sync pulse. Both the composite sync input and a periodic timing strobe arrive asynchronously. Each passes through a two-flop synchronizer and an edge detector before any decision is made.

A horizontal pulse of one clock follows every falling edge of composite sync. For vertical sync, the block measures how long composite sync stays low. Once that low time passes a threshold, the vertical pulse is aligned to a rising edge of the timing strobe. A configuration bit selects one of two detection methods. In the direct method, the pulse is issued on the next strobe rise. In the confirmed method, the block waits for the strobe's next low phase and issues the pulse at the strobe rise that ends it, but only if composite sync fell during that low phase.

A status flag classifies the shape of the vertical interval. It compares composite sync levels sampled at two fixed offsets after the detection point. After an enable rises, a settling counter holds the outputs quiet and raises a not-ready flag.

Top module: `csync_separator`

## Requirements
- R1: Each falling edge of `csync_in` yields exactly one `hsync_pulse`, which lasts one clock cycle.
- R2: `cfg_rdata` reads `{method, 7'b0000101}`. A write with `cfg_we` stores only bit 7 (0 = direct method, 1 = confirmed method), and the other written bits are ignored. After reset the method is 0.
- R3: In the direct method, a low period of `csync_in` longer than `THRESH_CYCLES` clocks yields exactly one `vsync_pulse` of one cycle, on a rising edge of the timing strobe.
- R4: A low period of `csync_in` no longer than the threshold yields no `vsync_pulse`.
- R5: In the confirmed method, a qualifying low period yields one `vsync_pulse` only if `csync_in` falls during the strobe low phase that follows qualification. Otherwise no pulse is issued.
- R6: At most one `vsync_pulse` is issued per qualifying low period. The detector re-arms only after `csync_in` has returned high.
- R7: `shape_flag` is 0 when `csync_in` has the same level at `SAMPLE_A` and `SAMPLE_B` clocks after the detection point, and 1 when the levels differ.
- R8: While `enable` is low, `hsync_pulse` and `vsync_pulse` stay low and `not_ready` is 1. After `enable` rises, `not_ready` stays 1 and the pulse outputs stay low for `SETTLE_CYCLES` clocks, and then `not_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low holds the outputs quiet |
| csync_in | input | 1 | Sliced composite sync, asynchronous |
| tstrobe_in | input | 1 | Periodic timing strobe, asynchronous |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data; only bit 7 is stored |
| cfg_rdata | output | 8 | Configuration readback |
| hsync_pulse | output | 1 | One-cycle horizontal sync pulse |
| vsync_pulse | output | 1 | One-cycle vertical sync pulse |
| shape_flag | output | 1 | Vertical interval shape status |
| not_ready | output | 1 | High while disabled or settling |

## Verification
The case that is hardest to reach is the confirmed method's positive path. Composite sync must qualify as a long low and then fall again inside the strobe's next low phase, and the strobe phase at qualification is not known from the ports. The bench makes this case certain by following the long low with a dense serration train whose period is far shorter than the strobe half-period, so a fall lands in any low phase. A plain long low is then used to show that no pulse results without that fall.

// File: rtl/csync_sep_pkg.sv
// Shared types and constants for the composite sync separator.
package csync_sep_pkg;

    // Fixed pattern returned in the low seven configuration bits.
    localparam logic [6:0] CFG_FIXED = 7'b0000101;

    // Vertical detector states.
    typedef enum logic [2:0] {
        VD_IDLE,       // measuring low width
        VD_WAIT_RISE,  // direct method: wait for strobe rise
        VD_WAIT_LOW,   // confirmed method: wait for strobe low phase
        VD_WATCH,      // confirmed method: look for csync fall
        VD_DONE        // wait for csync to return high
    } vd_state_t;

endpackage

// File: rtl/csync_edge_sync.sv
// Two-flop synchronizer followed by an edge detector.
// Assumes the input is asynchronous to clk. INIT is the idle level used at reset.
module csync_edge_sync #(
    parameter bit INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic level,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    // Synchronize and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
            prev_q <= INIT;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/csync_settle_timer.sv
// Counts settling time after enable rises. Assumes SETTLE_CYCLES >= 1.
module csync_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 4000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic ready
);
    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count up to the limit while enabled; clear when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = enable && (cnt_q == LIMIT);
endmodule

// File: rtl/csync_vert_detect.sv
// Vertical sync detector. Measures the low width of synchronized csync with a
// saturating counter. After qualification it aligns a one-cycle pulse to a
// strobe rise, using the direct or the confirmed method.
// Assumes the inputs are already synchronized. run low holds the detector idle.
module csync_vert_detect
    import csync_sep_pkg::*;
#(
    parameter int unsigned THRESH_CYCLES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic method,
    input  logic cs_level,
    input  logic cs_fall,
    input  logic ts_rise,
    input  logic ts_fall,
    output logic qualify,
    output logic vpulse
);
    localparam int unsigned CW = $clog2(THRESH_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH_CYCLES);

    vd_state_t   state_q;
    logic [CW-1:0] width_q;
    logic        seen_fall_q;

    // Saturating low-width counter, cleared while csync is high.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cs_level) begin
            width_q <= '0;
        end else if (width_q != LIMIT) begin
            width_q <= width_q + 1'b1;
        end
    end

    // The detection point: low width has reached the threshold while armed.
    assign qualify = (state_q == VD_IDLE) && !cs_level && (width_q == LIMIT);

    // Detection state machine and pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q     <= VD_IDLE;
            seen_fall_q <= 1'b0;
            vpulse      <= 1'b0;
        end else begin
            vpulse <= 1'b0;
            unique case (state_q)
                VD_IDLE: begin
                    if (qualify) state_q <= method ? VD_WAIT_LOW : VD_WAIT_RISE;
                end
                VD_WAIT_RISE: begin
                    if (ts_rise) begin
                        vpulse  <= 1'b1;
                        state_q <= VD_DONE;
                    end
                end
                VD_WAIT_LOW: begin
                    seen_fall_q <= 1'b0;
                    if (ts_fall) state_q <= VD_WATCH;
                end
                VD_WATCH: begin
                    if (ts_rise) begin
                        vpulse  <= seen_fall_q || cs_fall;
                        state_q <= VD_DONE;
                    end else if (cs_fall) begin
                        seen_fall_q <= 1'b1;
                    end
                end
                VD_DONE: begin
                    if (cs_level) state_q <= VD_IDLE;
                end
                default: state_q <= VD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/csync_shape_probe.sv
// Samples csync at two fixed offsets after the detection point and flags
// whether the two levels differ. Assumes 1 <= SAMPLE_A < SAMPLE_B.
module csync_shape_probe #(
    parameter int unsigned SAMPLE_A = 16,
    parameter int unsigned SAMPLE_B = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cs_level,
    output logic shape
);
    localparam int unsigned CW = $clog2(SAMPLE_B + 1);
    localparam logic [CW-1:0] OFF_A = CW'(SAMPLE_A);
    localparam logic [CW-1:0] OFF_B = CW'(SAMPLE_B);

    logic [CW-1:0] off_q;
    logic          busy_q;
    logic          a_q;

    // Offset counter, sample A capture and shape comparison at sample B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            busy_q <= 1'b0;
            a_q    <= 1'b0;
            shape  <= 1'b0;
        end else if (start) begin
            off_q  <= CW'(1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            off_q <= off_q + 1'b1;
            if (off_q == OFF_A) a_q <= cs_level;
            if (off_q == OFF_B) begin
                shape  <= a_q ^ cs_level;
                busy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/csync_separator.sv
// Composite sync separator top. It synchronizes csync and the timing strobe,
// emits horizontal one-shots, detects vertical sync with a selectable method,
// reports the vertical shape, and gates the outputs during settling.
// Assumes clk runs continuously. The default THRESH_CYCLES is 8 us at 200 MHz.
module csync_separator
    import csync_sep_pkg::*;
#(
    parameter int unsigned THRESH_CYCLES = 1600,
    parameter int unsigned SETTLE_CYCLES = 4000000,
    parameter int unsigned SAMPLE_A      = 16,
    parameter int unsigned SAMPLE_B      = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       csync_in,
    input  logic       tstrobe_in,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       hsync_pulse,
    output logic       vsync_pulse,
    output logic       shape_flag,
    output logic       not_ready
);
    logic cs_level, cs_rise, cs_fall;
    logic ts_level, ts_rise, ts_fall;
    logic ready, active;
    logic method_q;
    logic hs_q;
    logic qualify, vpulse;

    csync_edge_sync #(.INIT(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d_async(csync_in),
        .level(cs_level), .rise(cs_rise), .fall(cs_fall)
    );

    csync_edge_sync #(.INIT(1'b0)) u_ts_sync (
        .clk(clk), .rst_n(rst_n), .d_async(tstrobe_in),
        .level(ts_level), .rise(ts_rise), .fall(ts_fall)
    );

    csync_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ready(ready)
    );

    assign active    = enable && ready;
    assign not_ready = !active;

    // Configuration register: only the method bit is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) method_q <= 1'b0;
        else if (cfg_we) method_q <= cfg_wdata[7];
    end

    assign cfg_rdata = {method_q, CFG_FIXED};

    // Horizontal one-shot registered from the csync falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else hs_q <= cs_fall && active;
    end

    csync_vert_detect #(.THRESH_CYCLES(THRESH_CYCLES)) u_vdet (
        .clk(clk), .rst_n(rst_n), .run(active), .method(method_q),
        .cs_level(cs_level), .cs_fall(cs_fall),
        .ts_rise(ts_rise), .ts_fall(ts_fall),
        .qualify(qualify), .vpulse(vpulse)
    );

    csync_shape_probe #(.SAMPLE_A(SAMPLE_A), .SAMPLE_B(SAMPLE_B)) u_shape (
        .clk(clk), .rst_n(rst_n), .start(qualify),
        .cs_level(cs_level), .shape(shape_flag)
    );

    assign hsync_pulse = hs_q && active;
    assign vsync_pulse = vpulse && active;

    logic unused_ok;
    assign unused_ok = ts_level ^ cs_rise ^ (^cfg_wdata[6:0]);
endmodule

// File: rtl/csync_separator_chk.sv
// Property checker for the composite sync separator, bound to the top module.
module csync_separator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic [7:0] cfg_rdata,
    input logic       hsync_pulse,
    input logic       vsync_pulse,
    input logic       not_ready
);
    // R1
    hsync_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_pulse |=> !hsync_pulse);

    // R3
    vsync_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_pulse |=> !vsync_pulse);

    // R2
    cfg_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:0] == 7'b0000101);

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (not_ready && !hsync_pulse && !vsync_pulse));

    // R8
    settling_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_ready |-> (!hsync_pulse && !vsync_pulse));
endmodule

bind csync_separator csync_separator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_rdata(cfg_rdata),
    .hsync_pulse(hsync_pulse), .vsync_pulse(vsync_pulse), .not_ready(not_ready)
);

// File: tb/test_csync_separator.sv
// Directed bench for the composite sync separator.
module test_csync_separator;
    localparam int unsigned THRESH = 40;
    localparam int unsigned SETTLE = 20;
    localparam int unsigned SA     = 8;
    localparam int unsigned SB     = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       csync_in = 1'b1;
    logic       tstrobe_in = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       hsync_pulse, vsync_pulse, shape_flag, not_ready;

    int tests = 0;
    int fails = 0;
    int hs_cnt = 0;
    int vs_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    csync_separator #(
        .THRESH_CYCLES(THRESH), .SETTLE_CYCLES(SETTLE),
        .SAMPLE_A(SA), .SAMPLE_B(SB)
    ) i_csync_separator (
        .clk(clk), .rst_n(rst_n), .enable(enable), .csync_in(csync_in),
        .tstrobe_in(tstrobe_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .hsync_pulse(hsync_pulse),
        .vsync_pulse(vsync_pulse), .shape_flag(shape_flag), .not_ready(not_ready)
    );

    // Free-running timing strobe: 32 cycles high, 32 low.
    initial begin
        forever begin
            repeat (32) @(negedge clk);
            tstrobe_in = ~tstrobe_in;
        end
    end

    // Pulse counters sampled away from the active edge.
    always @(negedge clk) begin
        if (hsync_pulse) hs_cnt++;
        if (vsync_pulse) vs_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low_pulse(input int width);
        csync_in = 1'b0;
        idle(width);
        csync_in = 1'b1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        cfg_wdata = d;
        cfg_we = 1'b1;
        idle(1);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset;
        idle(1);
        check("R2 reset readback", cfg_rdata, 8'h05);
        check("R8 reset not_ready", not_ready, 1);
        check("R1 reset hsync", hsync_pulse, 0);
        check("R3 reset vsync", vsync_pulse, 0);
    endtask

    task automatic t_disabled;
        int h0;
        h0 = hs_cnt;
        repeat (3) begin low_pulse(6); idle(10); end
        idle(10);
        check("R8 disabled hsync count", hs_cnt - h0, 0);
    endtask

    task automatic t_settle;
        int h0;
        h0 = hs_cnt;
        enable = 1'b1;
        idle(2);
        low_pulse(3);
        idle(5);
        check("R8 settling not_ready", not_ready, 1);
        check("R8 settling hsync", hs_cnt - h0, 0);
        idle(SETTLE);
        check("R8 ready after settle", not_ready, 0);
    endtask

    task automatic t_hsync;
        int h0, v0;
        h0 = hs_cnt; v0 = vs_cnt;
        for (int i = 0; i < 5; i++) begin low_pulse(10); idle(12); end
        low_pulse(THRESH - 10); idle(100);
        check("R1 hsync per fall", hs_cnt - h0, 6);
        check("R4 short lows no vsync", vs_cnt - v0, 0);
    endtask

    task automatic t_cfg;
        write_cfg(8'hFF);
        check("R2 write ones", cfg_rdata, 8'h85);
        write_cfg(8'h00);
        check("R2 write zeros", cfg_rdata, 8'h05);
        write_cfg(8'h7A);
        check("R2 other bits ignored", cfg_rdata, 8'h05);
    endtask

    task automatic t_direct;
        int v0;
        write_cfg(8'h00);
        v0 = vs_cnt;
        low_pulse(100); idle(120);
        check("R3 direct one vsync", vs_cnt - v0, 1);
        v0 = vs_cnt;
        low_pulse(400); idle(120);
        check("R6 long low one vsync", vs_cnt - v0, 1);
    endtask

    task automatic t_confirmed;
        int v0;
        write_cfg(8'h80);
        v0 = vs_cnt;
        low_pulse(100); idle(200);
        check("R5 confirmed no fall no vsync", vs_cnt - v0, 0);
        v0 = vs_cnt;
        low_pulse(THRESH + 10);
        for (int i = 0; i < 40; i++) begin idle(4); low_pulse(4); end
        idle(150);
        check("R5 confirmed with fall one vsync", vs_cnt - v0, 1);
        write_cfg(8'h00);
    endtask

    task automatic t_shape;
        low_pulse(THRESH + SB + 30); idle(80);
        check("R7 equal levels shape 0", shape_flag, 0);
        low_pulse(THRESH + SA + 8); idle(80);
        check("R7 different levels shape 1", shape_flag, 1);
        low_pulse(THRESH + SB + 30); idle(80);
        check("R7 back to equal shape 0", shape_flag, 0);
    endtask

    task automatic t_disable_again;
        int h0, v0;
        enable = 1'b0;
        idle(2);
        h0 = hs_cnt; v0 = vs_cnt;
        check("R8 not_ready on disable", not_ready, 1);
        low_pulse(100); idle(100);
        check("R8 disabled no pulses", (hs_cnt - h0) + (vs_cnt - v0), 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_settle();
        t_hsync();
        t_cfg();
        t_direct();
        t_confirmed();
        t_shape();
        t_disable_again();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule